// File: doc/BRIEF.md
# Hot-Plug Slot Fault Latch

This block holds the fault reporting logic for a power controller that serves two hot-plug slots. For each slot it takes the comparator flags from the analog front end: undervoltage on either main rail, a fast overcurrent trip, a slow overcurrent trip, a slow overcurrent trip on the auxiliary rail, and a slot over-temperature flag. It also takes one over-temperature flag for the whole die. From these flags it latches a main fault and an auxiliary fault for each slot. The two latches are separate, and each one is gated by its own enable. Both fault outputs are active low and behave like open-drain pins: low means a fault is reported.

A slow overcurrent trip counts as a fault only after a digital filter has seen it held for a programmable number of clock cycles. A latched fault stays latched after its cause goes away. It clears only when its own enable goes from high to low, and that same edge resets the breaker filters behind it. For diagnostics, a force-on input (active low) releases the slot's fault outputs and its two power-good outputs, which are passed through from the sequencer. The latches keep their state while the force is applied. All inputs go through two-flop synchronizers, so each cause takes three clock edges to reach an output.

Top module: `hp_slot_fault`

## Requirements
- R1: While por_n is low, and after it is released until some enabled cause appears, every main_fault_n and aux_fault_n bit reads 1. This holds even when causes and enables are present during reset.
- R2: With main_en high, any of uv_hi, uv_lo or fast_oc sets main_fault_n low on the third rising edge after the inputs change. When main_en is low, none of them has any effect.
- R3: slow_oc held high with main_en high sets main_fault_n low on edge filt_limit+3, and a filt_limit of 0 acts as 1. A pulse shorter than filt_limit cycles is discarded and restarts the count.
- R4: A latched main fault stays low after its cause is removed. It clears only on the third edge after that slot's main_en falls. The other slot's enable has no effect on it.
- R5: With aux_en high, aux_oc together with slot_ot sets aux_fault_n low on the third edge. aux_oc alone sets it low on edge filt_limit+3.
- R6: glob_ot sets aux_fault_n low on the third edge in every slot whose aux_en is high.
- R7: A latched auxiliary fault clears only on the third edge after its own aux_en falls. Main and auxiliary latches never set or clear each other.
- R8: On the second edge after force_on_n[i] goes low, main_fault_n[i], aux_fault_n[i], pg_n[i] and dpg_n[i] all read 1. The latched faults reappear two edges after the force is released.
- R9: When not forced, pg_n and dpg_n follow pg_raw_n and dpg_raw_n combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| filt_limit | input | CNT_W | Slow overcurrent filter length in cycles (0 acts as 1) |
| glob_ot | input | 1 | Die over-temperature flag, shared by all slots |
| uv_hi | input | NUM_SLOTS | Undervoltage on the higher main rail |
| uv_lo | input | NUM_SLOTS | Undervoltage on the lower main rail |
| fast_oc | input | NUM_SLOTS | Fast overcurrent breaker trip |
| slow_oc | input | NUM_SLOTS | Slow overcurrent breaker trip on the main rails |
| aux_oc | input | NUM_SLOTS | Slow overcurrent trip on the auxiliary rail |
| slot_ot | input | NUM_SLOTS | Slot over-temperature flag |
| main_en | input | NUM_SLOTS | Main power enable |
| aux_en | input | NUM_SLOTS | Auxiliary power enable |
| force_on_n | input | NUM_SLOTS | Diagnostic force-on, active low |
| pg_raw_n | input | NUM_SLOTS | Power-good from the sequencer, active low |
| dpg_raw_n | input | NUM_SLOTS | Delayed power-good from the sequencer, active low |
| main_fault_n | output | NUM_SLOTS | Main fault, active low |
| aux_fault_n | output | NUM_SLOTS | Auxiliary fault, active low |
| pg_n | output | NUM_SLOTS | Power-good after force masking |
| dpg_n | output | NUM_SLOTS | Delayed power-good after force masking |

## Verification
The case that is hardest to reach from the ports is a slow overcurrent pulse that ends one cycle before the filter expires. The input must be held for exactly filt_limit-1 raw cycles, measured through the synchronizer delay. The bench sweeps filt_limit over a small counter and times each pulse in whole cycles from a falling clock edge. It then applies a full-length pulse and checks that the fault lands on the same edge as it would from a clean start, which shows the count was restarted. A force applied over faults that are already latched is reached by latching first and then toggling force_on_n. The bench checks that the faults come back once the force is released.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

    // Per-slot comparator and control inputs, in the order the sync stage carries them.
    typedef struct packed {
        logic uv_hi;
        logic uv_lo;
        logic fast_oc;
        logic slow_oc;
        logic aux_oc;
        logic slot_ot;
        logic main_en;
        logic aux_en;
        logic force_n;
    } slot_in_t;

    localparam int SLOT_IN_W = $bits(slot_in_t);

    // Value the synchronizer holds in reset: nothing enabled and no force applied.
    localparam slot_in_t SLOT_IN_IDLE = '{force_n: 1'b1, default: 1'b0};

endpackage

// File: rtl/hpf_sync.sv
module hpf_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/hpf_filter.sv
module hpf_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             trip,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             exp;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            // Enable low: breaker reset, count discarded.
            st_d = '0;
        end else if (!st_q.exp) begin
            if (trip) begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_d.cnt >= limit) begin
                    st_d.exp = 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = st_q.exp;
endmodule

// File: rtl/hpf_slot.sv
module hpf_slot
    import hpf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  slot_in_t         sin,
    input  logic             glob_ot,
    input  logic [CNT_W-1:0] limit,
    input  logic             pg_raw_n,
    input  logic             dpg_raw_n,
    output logic             main_fault_n,
    output logic             aux_fault_n,
    output logic             pg_n,
    output logic             dpg_n,
    output logic             main_flt,
    output logic             aux_flt
);
    typedef struct packed {
        logic men_q;
        logic aen_q;
        logic mflt;
        logic aflt;
    } slot_st_t;

    slot_st_t st_d, st_q;
    logic     m_exp, a_exp;
    logic     m_fall, a_fall;
    logic     m_cause, a_cause;

    hpf_filter #(.CNT_W(CNT_W)) main_filt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (sin.main_en),
        .trip    (sin.slow_oc),
        .limit   (limit),
        .expired (m_exp)
    );

    hpf_filter #(.CNT_W(CNT_W)) aux_filt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (sin.aux_en),
        .trip    (sin.aux_oc),
        .limit   (limit),
        .expired (a_exp)
    );

    always_comb begin
        st_d       = st_q;
        st_d.men_q = sin.main_en;
        st_d.aen_q = sin.aux_en;

        m_fall  = st_q.men_q & ~sin.main_en;
        a_fall  = st_q.aen_q & ~sin.aux_en;
        m_cause = sin.uv_hi | sin.uv_lo | sin.fast_oc | m_exp;
        a_cause = a_exp | (sin.aux_oc & sin.slot_ot) | glob_ot;

        if (m_fall) begin
            st_d.mflt = 1'b0;
        end else if (sin.main_en && m_cause) begin
            st_d.mflt = 1'b1;
        end

        if (a_fall) begin
            st_d.aflt = 1'b0;
        end else if (sin.aux_en && a_cause) begin
            st_d.aflt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Open-drain style: low only when latched and not forced on.
    assign main_fault_n = ~(st_q.mflt & sin.force_n);
    assign aux_fault_n  = ~(st_q.aflt & sin.force_n);
    assign pg_n         = sin.force_n ? pg_raw_n  : 1'b1;
    assign dpg_n        = sin.force_n ? dpg_raw_n : 1'b1;
    assign main_flt     = st_q.mflt;
    assign aux_flt      = st_q.aflt;
endmodule

// File: rtl/hp_slot_fault.sv
module hp_slot_fault
    import hpf_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic [CNT_W-1:0]     filt_limit,
    input  logic                 glob_ot,
    input  logic [NUM_SLOTS-1:0] uv_hi,
    input  logic [NUM_SLOTS-1:0] uv_lo,
    input  logic [NUM_SLOTS-1:0] fast_oc,
    input  logic [NUM_SLOTS-1:0] slow_oc,
    input  logic [NUM_SLOTS-1:0] aux_oc,
    input  logic [NUM_SLOTS-1:0] slot_ot,
    input  logic [NUM_SLOTS-1:0] main_en,
    input  logic [NUM_SLOTS-1:0] aux_en,
    input  logic [NUM_SLOTS-1:0] force_on_n,
    input  logic [NUM_SLOTS-1:0] pg_raw_n,
    input  logic [NUM_SLOTS-1:0] dpg_raw_n,
    output logic [NUM_SLOTS-1:0] main_fault_n,
    output logic [NUM_SLOTS-1:0] aux_fault_n,
    output logic [NUM_SLOTS-1:0] pg_n,
    output logic [NUM_SLOTS-1:0] dpg_n
);
    logic                 s_glob;
    logic [NUM_SLOTS-1:0] s_men, s_aen, s_force_n;
    logic [NUM_SLOTS-1:0] mflt, aflt;

    hpf_sync #(.W(1), .RST_VAL(1'b0)) glob_sync_i (
        .clk   (clk),
        .rst_n (por_n),
        .din   (glob_ot),
        .dout  (s_glob)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        slot_in_t raw_in, sync_in;

        always_comb begin
            raw_in         = SLOT_IN_IDLE;
            raw_in.uv_hi   = uv_hi[i];
            raw_in.uv_lo   = uv_lo[i];
            raw_in.fast_oc = fast_oc[i];
            raw_in.slow_oc = slow_oc[i];
            raw_in.aux_oc  = aux_oc[i];
            raw_in.slot_ot = slot_ot[i];
            raw_in.main_en = main_en[i];
            raw_in.aux_en  = aux_en[i];
            raw_in.force_n = force_on_n[i];
        end

        hpf_sync #(.W(SLOT_IN_W), .RST_VAL(SLOT_IN_W'(SLOT_IN_IDLE))) in_sync_i (
            .clk   (clk),
            .rst_n (por_n),
            .din   (raw_in),
            .dout  (sync_in)
        );

        hpf_slot #(.CNT_W(CNT_W)) slot_i (
            .clk          (clk),
            .rst_n        (por_n),
            .sin          (sync_in),
            .glob_ot      (s_glob),
            .limit        (filt_limit),
            .pg_raw_n     (pg_raw_n[i]),
            .dpg_raw_n    (dpg_raw_n[i]),
            .main_fault_n (main_fault_n[i]),
            .aux_fault_n  (aux_fault_n[i]),
            .pg_n         (pg_n[i]),
            .dpg_n        (dpg_n[i]),
            .main_flt     (mflt[i]),
            .aux_flt      (aflt[i])
        );

        assign s_men[i]     = sync_in.main_en;
        assign s_aen[i]     = sync_in.aux_en;
        assign s_force_n[i] = sync_in.force_n;
    end
endmodule

// File: rtl/hpf_chk.sv
module hpf_chk #(
    parameter int NUM_SLOTS = 2
) (
    input logic                 clk,
    input logic                 por_n,
    input logic                 s_glob,
    input logic [NUM_SLOTS-1:0] s_men,
    input logic [NUM_SLOTS-1:0] s_aen,
    input logic [NUM_SLOTS-1:0] s_force_n,
    input logic [NUM_SLOTS-1:0] mflt,
    input logic [NUM_SLOTS-1:0] aflt,
    input logic [NUM_SLOTS-1:0] main_fault_n,
    input logic [NUM_SLOTS-1:0] aux_fault_n,
    input logic [NUM_SLOTS-1:0] pg_n,
    input logic [NUM_SLOTS-1:0] dpg_n
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        // R2
        main_set_needs_en_chk: assert property (@(posedge clk) disable iff (!por_n)
            $rose(mflt[i]) |-> $past(s_men[i]))
            else $error("main fault set while main enable low, slot %0d", i);

        // R4
        main_clear_on_fall_chk: assert property (@(posedge clk) disable iff (!por_n)
            $fell(mflt[i]) |-> ($past(s_men[i], 2) && !$past(s_men[i])))
            else $error("main fault cleared without main enable fall, slot %0d", i);

        // R5
        aux_set_needs_en_chk: assert property (@(posedge clk) disable iff (!por_n)
            $rose(aflt[i]) |-> $past(s_aen[i]))
            else $error("aux fault set while aux enable low, slot %0d", i);

        // R7
        aux_clear_on_fall_chk: assert property (@(posedge clk) disable iff (!por_n)
            $fell(aflt[i]) |-> ($past(s_aen[i], 2) && !$past(s_aen[i])))
            else $error("aux fault cleared without aux enable fall, slot %0d", i);

        // R6
        glob_sets_aux_chk: assert property (@(posedge clk) disable iff (!por_n)
            (s_glob && s_aen[i]) |=> aflt[i])
            else $error("global over-temperature did not set aux fault, slot %0d", i);

        // R8
        force_masks_chk: assert property (@(posedge clk) disable iff (!por_n)
            !s_force_n[i] |-> (main_fault_n[i] && aux_fault_n[i] && pg_n[i] && dpg_n[i]))
            else $error("forced slot %0d drives a status output", i);
    end
endmodule

bind hp_slot_fault hpf_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
    .clk          (clk),
    .por_n        (por_n),
    .s_glob       (s_glob),
    .s_men        (s_men),
    .s_aen        (s_aen),
    .s_force_n    (s_force_n),
    .mflt         (mflt),
    .aflt         (aflt),
    .main_fault_n (main_fault_n),
    .aux_fault_n  (aux_fault_n),
    .pg_n         (pg_n),
    .dpg_n        (dpg_n)
);

// File: tb/hp_slot_fault_tb_top.sv
module hp_slot_fault_tb_top;
    localparam int N  = 2;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          por_n;
    logic [CW-1:0] filt_limit;
    logic          glob_ot;
    logic [N-1:0]  uv_hi, uv_lo, fast_oc, slow_oc, aux_oc, slot_ot;
    logic [N-1:0]  main_en, aux_en, force_on_n, pg_raw_n, dpg_raw_n;
    logic [N-1:0]  main_fault_n, aux_fault_n, pg_n, dpg_n;

    int  vectors = 0;
    int  miscmp  = 0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;

    hp_slot_fault #(.NUM_SLOTS(N), .CNT_W(CW)) dut_i (
        .clk(clk), .por_n(por_n), .filt_limit(filt_limit), .glob_ot(glob_ot),
        .uv_hi(uv_hi), .uv_lo(uv_lo), .fast_oc(fast_oc), .slow_oc(slow_oc),
        .aux_oc(aux_oc), .slot_ot(slot_ot), .main_en(main_en), .aux_en(aux_en),
        .force_on_n(force_on_n), .pg_raw_n(pg_raw_n), .dpg_raw_n(dpg_raw_n),
        .main_fault_n(main_fault_n), .aux_fault_n(aux_fault_n),
        .pg_n(pg_n), .dpg_n(dpg_n)
    );

    task automatic chk(string req, string what, logic [N-1:0] got, logic [N-1:0] exp);
        vectors++;
        if (got !== exp) begin
            miscmp++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_in();
        glob_ot = 1'b0; uv_hi = '0; uv_lo = '0; fast_oc = '0; slow_oc = '0;
        aux_oc = '0; slot_ot = '0; main_en = '0; aux_en = '0;
        force_on_n = '1; pg_raw_n = '1; dpg_raw_n = '1;
    endtask

    task automatic reset_dut(int lim);
        idle_in();
        filt_limit = CW'(lim);
        por_n = 1'b0;
        step(3);
        por_n = 1'b1;
        step(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        idle_in();
        filt_limit = '0;
        por_n = 1'b0;
        step(1);
        // R1: causes present during reset
        main_en = '1; aux_en = '1; fast_oc = '1; glob_ot = 1'b1;
        step(4);
        chk("R1", "main in reset", main_fault_n, '1);
        chk("R1", "aux in reset", aux_fault_n, '1);
        idle_in();
        por_n = 1'b1;
        step(6);
        chk("R1", "main after reset", main_fault_n, '1);
        chk("R1", "aux after reset", aux_fault_n, '1);

        // R2: main cause sweep per slot
        for (int s = 0; s < N; s++) begin
            for (int m = 0; m < 16; m++) begin
                logic [N-1:0] e;
                reset_dut(15);
                main_en[s] = m[0]; uv_hi[s] = m[1]; uv_lo[s] = m[2]; fast_oc[s] = m[3];
                step(2);
                chk("R2", "main before latency", main_fault_n, '1);
                step(1);
                e = '1;
                if (m[0] && (m[1] || m[2] || m[3])) e[s] = 1'b0;
                chk("R2", "main after latency", main_fault_n, e);
                chk("R2", "aux untouched", aux_fault_n, '1);
            end
        end

        // R3: slow filter timing, limit 0 acts as 1
        for (int s = 0; s < N; s++) begin
            for (int lim = 0; lim < 7; lim++) begin
                int leff;
                logic [N-1:0] e;
                leff = (lim == 0) ? 1 : lim;
                reset_dut(lim);
                main_en[s] = 1'b1;
                step(3);
                slow_oc[s] = 1'b1;
                step(leff + 2);
                chk("R3", "slow before expiry", main_fault_n, '1);
                step(1);
                e = '1; e[s] = 1'b0;
                chk("R3", "slow at expiry", main_fault_n, e);
            end
            // R3: short pulse discarded, count restarts
            for (int lim = 2; lim < 7; lim++) begin
                logic [N-1:0] e;
                reset_dut(lim);
                main_en[s] = 1'b1;
                step(3);
                slow_oc[s] = 1'b1;
                step(lim - 1);
                slow_oc[s] = 1'b0;
                step(lim + 4);
                chk("R3", "short pulse", main_fault_n, '1);
                slow_oc[s] = 1'b1;
                step(lim + 2);
                chk("R3", "restart before expiry", main_fault_n, '1);
                step(1);
                e = '1; e[s] = 1'b0;
                chk("R3", "restart expiry", main_fault_n, e);
            end
        end

        // R4: latch persists, clears on own enable fall only
        reset_dut(15);
        main_en[0] = 1'b1; fast_oc[0] = 1'b1;
        step(3);
        chk("R4", "latched", main_fault_n, 2'b10);
        fast_oc[0] = 1'b0;
        main_en[1] = 1'b1;
        step(6);
        main_en[1] = 1'b0;
        step(6);
        chk("R4", "persists after cause and other enable", main_fault_n, 2'b10);
        main_en[0] = 1'b0;
        step(2);
        chk("R4", "clear latency", main_fault_n, 2'b10);
        step(1);
        chk("R4", "cleared", main_fault_n, 2'b11);
        main_en[0] = 1'b1;
        step(5);
        chk("R4", "re-enable without cause", main_fault_n, 2'b11);

        // R5/R6: aux cause sweep per slot
        for (int s = 0; s < N; s++) begin
            for (int m = 0; m < 16; m++) begin
                logic [N-1:0] e;
                reset_dut(15);
                aux_en[s] = m[0]; aux_oc[s] = m[1]; slot_ot[s] = m[2]; glob_ot = m[3];
                step(2);
                chk("R5", "aux before latency", aux_fault_n, '1);
                step(1);
                e = '1;
                if (m[0] && ((m[1] && m[2]) || m[3])) e[s] = 1'b0;
                chk("R5", "aux after latency", aux_fault_n, e);
                chk("R5", "main untouched", main_fault_n, '1);
            end
            // R5: aux overcurrent filtered
            for (int lim = 1; lim < 6; lim += 2) begin
                logic [N-1:0] e;
                reset_dut(lim);
                aux_en[s] = 1'b1;
                step(3);
                aux_oc[s] = 1'b1;
                step(lim + 2);
                chk("R5", "aux filter before expiry", aux_fault_n, '1);
                step(1);
                e = '1; e[s] = 1'b0;
                chk("R5", "aux filter expiry", aux_fault_n, e);
            end
        end

        // R6: global over-temperature hits every enabled slot
        reset_dut(15);
        aux_en = '1; glob_ot = 1'b1;
        step(2);
        chk("R6", "global before latency", aux_fault_n, '1);
        step(1);
        chk("R6", "global both slots", aux_fault_n, '0);

        // R7: independent latches and clears
        reset_dut(15);
        main_en[0] = 1'b1; aux_en[0] = 1'b1; fast_oc[0] = 1'b1;
        aux_oc[0] = 1'b1; slot_ot[0] = 1'b1;
        step(3);
        fast_oc[0] = 1'b0; aux_oc[0] = 1'b0; slot_ot[0] = 1'b0;
        aux_en[0] = 1'b0;
        step(3);
        chk("R7", "aux cleared", aux_fault_n, 2'b11);
        chk("R7", "main kept by aux fall", main_fault_n, 2'b10);
        aux_en[0] = 1'b1; aux_oc[0] = 1'b1; slot_ot[0] = 1'b1;
        step(3);
        aux_oc[0] = 1'b0; slot_ot[0] = 1'b0;
        main_en[0] = 1'b0;
        step(3);
        chk("R7", "main cleared", main_fault_n, 2'b11);
        chk("R7", "aux kept by main fall", aux_fault_n, 2'b10);

        // R8/R9: force masking and power-good pass-through
        reset_dut(15);
        main_en = '1; aux_en = '1; fast_oc = '1; glob_ot = 1'b1;
        pg_raw_n = '0; dpg_raw_n = '0;
        step(4);
        chk("R8", "faults latched", main_fault_n & aux_fault_n, '0);
        chk("R9", "pg pass", pg_n | dpg_n, '0);
        force_on_n[0] = 1'b0;
        step(1);
        chk("R8", "force not yet seen", main_fault_n, '0);
        step(1);
        chk("R8", "forced main", main_fault_n, 2'b01);
        chk("R8", "forced aux", aux_fault_n, 2'b01);
        chk("R8", "forced pg", pg_n, 2'b01);
        chk("R8", "forced dpg", dpg_n, 2'b01);
        fast_oc = '0; glob_ot = 1'b0;
        force_on_n = '1;
        step(2);
        chk("R8", "latch retained main", main_fault_n, '0);
        chk("R8", "latch retained aux", aux_fault_n, '0);
        for (int v = 0; v < 4; v++) begin
            pg_raw_n = v[1:0]; dpg_raw_n = ~v[1:0];
            #1;
            chk("R9", "pg follow", pg_n, v[1:0]);
            chk("R9", "dpg follow", dpg_n, ~v[1:0]);
            step(1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule